// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Stall Watchdog

This block turns the two phase signals of an incremental shaft encoder into a signed position count. Both phases, the index pulse and the home switch each pass through a digital glitch filter whose length is set at a port. The filtered phase pair is treated as a two-bit Gray code. Every legal transition moves the position count by one, so each encoder line yields four counts.

A second signed register, the position difference, counts the same steps. It can be cleared at any time without losing a step, which lets a speed loop read motion per sample period on both fast and slow shafts. When both phases change together, nothing is counted and a sticky illegal flag is raised.

A motion watchdog measures the clocks since the last counted step. It raises a sticky timeout when the programmed interval passes with no motion. A rising edge of the filtered index input can optionally zero the position count.

Top module: `qdec_top`

## Requirements
- R1: After reset, `pos` and `diff` are 0, `dir_up`, `illegal` and `wd_timeout` are 0, and all four filtered outputs are 0.
- R2: A filtered output takes the raw level only after the raw input has differed from it on N consecutive rising clock edges, where N = `filt_len`, or N = 1 when `filt_len` is 0. It updates on the N-th such edge. A pulse shorter than N edges leaves the filtered output unchanged.
- R3: With the filtered phases read as {A,B}, the sequence 00→01→11→10→00 adds one to `pos` per transition and the reverse sequence subtracts one. The change appears one clock after the filtered phases change.
- R4: A transition in which both filtered phases change at once leaves `pos` unchanged and sets `illegal`. `illegal` stays set until `ill_clr` is asserted with no new illegal transition.
- R5: `dir_up` is 1 after the most recent counted step was upward and 0 after it was downward.
- R6: `diff` counts the same steps as `pos`. On a clock edge with `diff_clr` high, `diff` is loaded with that cycle's step (+1, −1 or 0), so a step is never lost.
- R7: When `idx_zero_en` is 1, a rising edge of the filtered index sets `pos` to 0 one clock later, taking precedence over a step. When it is 0, the index does not affect `pos`.
- R8: While `wd_en` is 1, `wd_timeout` is set on the clock edge `wd_limit`+1 clocks after the edge that counted the last step. A counted step reloads the interval. `wd_timeout` stays set until `wd_clr`.
- R9: `home_f` and `idx_f` follow the filter rule of R2 for their raw inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph_a_in | input | 1 | Raw phase A |
| ph_b_in | input | 1 | Raw phase B |
| idx_in | input | 1 | Raw index pulse |
| home_in | input | 1 | Raw home switch |
| filt_len | input | FILT_W | Consecutive samples needed to accept a level |
| idx_zero_en | input | 1 | Index rising edge zeroes the position |
| diff_clr | input | 1 | Restart the position difference |
| wd_en | input | 1 | Watchdog enable |
| wd_limit | input | WD_W | Watchdog interval in clocks |
| wd_clr | input | 1 | Clear watchdog timeout and interval |
| ill_clr | input | 1 | Clear the illegal-transition flag |
| ph_a_f | output | 1 | Filtered phase A |
| ph_b_f | output | 1 | Filtered phase B |
| idx_f | output | 1 | Filtered index |
| home_f | output | 1 | Filtered home |
| pos | output | POS_W | Signed position count |
| diff | output | POS_W | Signed position difference |
| dir_up | output | 1 | Direction of the last counted step |
| illegal | output | 1 | Sticky illegal-transition flag |
| wd_timeout | output | 1 | Sticky no-motion timeout |

## Verification
The hardest case to reach is an exact watchdog expiry. The stimulus has to stop moving right after a counted step and then count clocks to the edge on which the timeout must appear. The bench sets this up after a single directed step whose counting edge it knows, then samples one cycle before and one cycle after the expected edge. Illegal double-phase jumps and sub-threshold glitches also cannot come from a legal encoder. The bench drives them deliberately, mixed into a seeded random walk of legal steps and difference clears.

// File: rtl/qdec_pkg.sv
// Shared types for the quadrature decoder.
package qdec_pkg;
    // Difference of Gray-decoded phase codes (mod 4) maps straight onto these.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_ILL  = 2'd2,
        STEP_DN   = 2'd3
    } step_e;
endpackage

// File: rtl/qdec_filter.sv
// Glitch filter for one input.
// Accepts a new level after the raw input has differed from the current
// output on N consecutive clocks (N = len, or 1 when len is 0).
// Assumes the raw input is already synchronous to clk.
module qdec_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw,
    input  logic [FILT_W-1:0] len,
    output logic              filt
);
    logic [FILT_W-1:0] cnt;
    logic [FILT_W:0]   need;
    logic [FILT_W:0]   nxt;

    // Effective run length, never below one sample.
    assign need = (len == '0) ? (FILT_W+1)'(1) : {1'b0, len};
    assign nxt  = {1'b0, cnt} + (FILT_W+1)'(1);

    // Count disagreeing samples; adopt the raw level when the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt  <= '0;
        end else if (nxt >= need) begin
            filt <= raw;
            cnt  <= '0;
        end else begin
            cnt  <= nxt[FILT_W-1:0];
        end
    end
endmodule

// File: rtl/qdec_decode.sv
// Four-edge Gray decoder with position, difference, direction and illegal flag.
// Assumes phase inputs are filtered and change at most once per clock.
module qdec_decode
    import qdec_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a,
    input  logic             b,
    input  logic             idx,
    input  logic             idx_zero_en,
    input  logic             diff_clr,
    input  logic             ill_clr,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] diff,
    output logic             dir_up,
    output logic             illegal,
    output logic             step_valid
);
    logic [1:0]       prev_ab;
    logic             idx_prev;
    logic [1:0]       cur_bin;
    logic [1:0]       prev_bin;
    step_e            st;
    logic [POS_W-1:0] inc;
    logic             idx_rise;

    // Gray code to binary phase number, then modular difference gives the step.
    assign cur_bin  = {a, a ^ b};
    assign prev_bin = {prev_ab[1], prev_ab[1] ^ prev_ab[0]};
    assign st       = step_e'(cur_bin - prev_bin);
    assign step_valid = (st == STEP_UP) || (st == STEP_DN);
    assign idx_rise = idx && !idx_prev;

    // Signed increment for this cycle.
    always_comb begin
        case (st)
            STEP_UP: inc = POS_W'(1);
            STEP_DN: inc = '1;
            default: inc = '0;
        endcase
    end

    // Track previous phase state and update all counters and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ab  <= 2'b00;
            idx_prev <= 1'b0;
            pos      <= '0;
            diff     <= '0;
            dir_up   <= 1'b0;
            illegal  <= 1'b0;
        end else begin
            prev_ab  <= {a, b};
            idx_prev <= idx;
            if (idx_zero_en && idx_rise) pos <= '0;
            else                         pos <= pos + inc;
            if (diff_clr) diff <= inc;
            else          diff <= diff + inc;
            if (st == STEP_UP)      dir_up <= 1'b1;
            else if (st == STEP_DN) dir_up <= 1'b0;
            if (st == STEP_ILL)     illegal <= 1'b1;
            else if (ill_clr)       illegal <= 1'b0;
        end
    end
endmodule

// File: rtl/qdec_wdog.sv
// No-motion watchdog: counts clocks since the last counted step and raises
// a sticky timeout when the count reaches the limit. Idle while disabled.
module qdec_wdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [WD_W-1:0] limit,
    input  logic            clr,
    input  logic            kick,
    output logic            timeout
);
    logic [WD_W-1:0] cnt;

    // Interval counter with reload on motion, and the sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else begin
            if (clr || !en || kick) cnt <= '0;
            else if (cnt != limit)  cnt <= cnt + WD_W'(1);
            if (clr)                                timeout <= 1'b0;
            else if (en && !kick && cnt == limit)   timeout <= 1'b1;
        end
    end
endmodule

// File: rtl/qdec_top.sv
// Filtered quadrature decoder top: four input filters, the Gray decoder
// and the stall watchdog. All inputs are assumed synchronous to clk.
module qdec_top #(
    parameter int POS_W  = 16,
    parameter int FILT_W = 4,
    parameter int WD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_a_in,
    input  logic              ph_b_in,
    input  logic              idx_in,
    input  logic              home_in,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              idx_zero_en,
    input  logic              diff_clr,
    input  logic              wd_en,
    input  logic [WD_W-1:0]   wd_limit,
    input  logic              wd_clr,
    input  logic              ill_clr,
    output logic              ph_a_f,
    output logic              ph_b_f,
    output logic              idx_f,
    output logic              home_f,
    output logic [POS_W-1:0]  pos,
    output logic [POS_W-1:0]  diff,
    output logic              dir_up,
    output logic              illegal,
    output logic              wd_timeout
);
    localparam int N_IN = 4;

    logic [N_IN-1:0] raw_v;
    logic [N_IN-1:0] filt_v;
    logic            step_valid;

    assign raw_v = {home_in, idx_in, ph_b_in, ph_a_in};

    // One identical filter per input line.
    for (genvar i = 0; i < N_IN; i++) begin : g_filt
        qdec_filter #(.FILT_W(FILT_W)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[i]),
            .len  (filt_len),
            .filt (filt_v[i])
        );
    end

    assign ph_a_f = filt_v[0];
    assign ph_b_f = filt_v[1];
    assign idx_f  = filt_v[2];
    assign home_f = filt_v[3];

    qdec_decode #(.POS_W(POS_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .a          (filt_v[0]),
        .b          (filt_v[1]),
        .idx        (filt_v[2]),
        .idx_zero_en(idx_zero_en),
        .diff_clr   (diff_clr),
        .ill_clr    (ill_clr),
        .pos        (pos),
        .diff       (diff),
        .dir_up     (dir_up),
        .illegal    (illegal),
        .step_valid (step_valid)
    );

    qdec_wdog #(.WD_W(WD_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (wd_en),
        .limit  (wd_limit),
        .clr    (wd_clr),
        .kick   (step_valid),
        .timeout(wd_timeout)
    );
endmodule

// File: rtl/qdec_chk.sv
// Property checker for qdec_top, attached through bind.
module qdec_chk #(
    parameter int POS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ph_a_in,
    input logic             ph_a_f,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] diff,
    input logic             illegal,
    input logic             ill_clr,
    input logic             wd_timeout,
    input logic             wd_clr,
    input logic             diff_clr
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    // R3 / R7: position moves by at most one per clock, or is zeroed.
    p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pos == $past(pos) || pos == ($past(pos) + ONE) ||
                  pos == ($past(pos) - ONE) || pos == '0));

    // R2: the filtered level only ever moves to a level the raw input held.
    p_filt_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_a_f != $past(ph_a_f)) |-> (ph_a_f == $past(ph_a_in)));

    // R4: the illegal flag stays set until cleared.
    p_ill_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !ill_clr) |=> illegal);

    // R8: the timeout stays set until cleared.
    p_wd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_timeout && !wd_clr) |=> wd_timeout);

    // R6: a clear leaves at most one step in the difference.
    p_diff_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        diff_clr |=> (diff == '0 || diff == ONE || diff == '1));
endmodule

bind qdec_top qdec_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_a_in   (ph_a_in),
    .ph_a_f    (ph_a_f),
    .pos       (pos),
    .diff      (diff),
    .illegal   (illegal),
    .ill_clr   (ill_clr),
    .wd_timeout(wd_timeout),
    .wd_clr    (wd_clr),
    .diff_clr  (diff_clr)
);

// File: tb/qdec_top_tb.sv
module qdec_top_tb;
    localparam int PW  = 16;
    localparam int FW  = 4;
    localparam int WW  = 16;
    localparam int N   = 3;
    localparam int LIM = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph_a_in = 0, ph_b_in = 0, idx_in = 0, home_in = 0;
    logic [FW-1:0] filt_len = FW'(N);
    logic idx_zero_en = 0, diff_clr = 0, wd_en = 0, wd_clr = 0, ill_clr = 0;
    logic [WW-1:0] wd_limit = WW'(LIM);
    logic ph_a_f, ph_b_f, idx_f, home_f, dir_up, illegal, wd_timeout;
    logic [PW-1:0] pos, diff;

    int checks = 0;
    int errors = 0;
    int g = 0;
    logic [PW-1:0] m_pos = '0;
    logic [PW-1:0] m_diff = '0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    qdec_top #(.POS_W(PW), .FILT_W(FW), .WD_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ph_a_in(ph_a_in), .ph_b_in(ph_b_in),
        .idx_in(idx_in), .home_in(home_in), .filt_len(filt_len),
        .idx_zero_en(idx_zero_en), .diff_clr(diff_clr), .wd_en(wd_en),
        .wd_limit(wd_limit), .wd_clr(wd_clr), .ill_clr(ill_clr),
        .ph_a_f(ph_a_f), .ph_b_f(ph_b_f), .idx_f(idx_f), .home_f(home_f),
        .pos(pos), .diff(diff), .dir_up(dir_up), .illegal(illegal),
        .wd_timeout(wd_timeout)
    );

    // Gray code for phase number 0..3: 00, 01, 11, 10 as {A,B}.
    function automatic logic [1:0] gray_of(input int k);
        case (k & 3)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Legal step: drive next Gray code, wait for filter plus decode, check.
    task automatic step(input bit up);
        logic [1:0] c;
        g = up ? g + 1 : g + 3;
        c = gray_of(g);
        {ph_a_in, ph_b_in} = c;
        repeat (N + 2) @(negedge clk);
        m_pos  = up ? m_pos + PW'(1) : m_pos - PW'(1);
        m_diff = up ? m_diff + PW'(1) : m_diff - PW'(1);
        chk("R3 pos", int'(pos), int'(m_pos));
        chk("R6 diff", int'(diff), int'(m_diff));
        chk("R5 dir_up", int'(dir_up), int'(up));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pos", int'(pos), 0);
        chk("R1 diff", int'(diff), 0);
        chk("R1 flags", int'({dir_up, illegal, wd_timeout}), 0);
        chk("R1 filtered", int'({ph_a_f, ph_b_f, idx_f, home_f}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R2: exact filter latency on home
        home_in = 1'b1;
        repeat (N - 1) @(negedge clk);
        chk("R9 home_f before N", int'(home_f), 0);
        @(negedge clk);
        chk("R9 home_f at N", int'(home_f), 1);
        home_in = 1'b0;
        repeat (N - 1) @(negedge clk);
        home_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 short low glitch ignored", int'(home_f), 1);
        home_in = 1'b0;
        repeat (N + 1) @(negedge clk);

        // R2: phase glitch shorter than N does not count
        ph_a_in = 1'b1;
        repeat (N - 1) @(negedge clk);
        ph_a_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 ph_a_f glitch", int'(ph_a_f), 0);
        chk("R2 pos after glitch", int'(pos), 0);

        // R3 / R5: directed up then down sequence
        for (int i = 0; i < 5; i++) step(1'b1);
        for (int i = 0; i < 7; i++) step(1'b0);

        // R4: both phases jump at once
        g = g + 2;
        {ph_a_in, ph_b_in} = gray_of(g);
        repeat (N + 2) @(negedge clk);
        chk("R4 pos unchanged", int'(pos), int'(m_pos));
        chk("R4 illegal set", int'(illegal), 1);
        repeat (5) @(negedge clk);
        chk("R4 illegal sticky", int'(illegal), 1);
        ill_clr = 1'b1; @(negedge clk); ill_clr = 1'b0;
        chk("R4 illegal cleared", int'(illegal), 0);

        // Random walk with watchdog armed; steps are far faster than the limit
        wd_en = 1'b1;
        wd_clr = 1'b1; @(negedge clk); wd_clr = 1'b0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 6) begin
                diff_clr = 1'b1; @(negedge clk); diff_clr = 1'b0;
                m_diff = '0;
                chk("R6 diff after clear", int'(diff), 0);
            end else if (r == 7) begin
                ph_b_in = ~ph_b_in;
                repeat (1 + int'($urandom % (N - 1))) @(negedge clk);
                ph_b_in = ~ph_b_in;
                repeat (N + 1) @(negedge clk);
                chk("R2 random glitch pos", int'(pos), int'(m_pos));
            end else begin
                step(r[0]);
            end
        end
        chk("R8 no timeout while moving", int'(wd_timeout), 0);
        chk("R4 no illegal on legal walk", int'(illegal), 0);

        // R7: index zeroes position when enabled
        idx_zero_en = 1'b1;
        idx_in = 1'b1;
        repeat (N + 2) @(negedge clk);
        m_pos = '0;
        chk("R7 index zero", int'(pos), 0);
        idx_in = 1'b0;
        repeat (N + 1) @(negedge clk);
        step(1'b1);
        idx_zero_en = 1'b0;
        idx_in = 1'b1;
        repeat (N + 2) @(negedge clk);
        chk("R7 index ignored when disabled", int'(pos), int'(m_pos));
        idx_in = 1'b0;
        repeat (N + 1) @(negedge clk);

        // R8: exact watchdog expiry after last counted step
        wd_clr = 1'b1; @(negedge clk); wd_clr = 1'b0;
        step(1'b0);
        repeat (LIM - 1) @(negedge clk);
        chk("R8 no timeout before limit", int'(wd_timeout), 0);
        repeat (2) @(negedge clk);
        chk("R8 timeout at limit", int'(wd_timeout), 1);
        step(1'b1);
        chk("R8 timeout sticky", int'(wd_timeout), 1);
        wd_clr = 1'b1; @(negedge clk); wd_clr = 1'b0;
        chk("R8 timeout cleared", int'(wd_timeout), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule